// File: doc/BRIEF.md
# Text-Message Alert Command Sequencer

This block turns a one-character verdict from a host computer into a complete text-message transaction toward a cellular modem. The host and the modem share one serial pair. A select output chooses which far device is connected: low connects the host, high connects the modem. The block feeds bytes to a UART transmitter through a valid/ready byte interface and reads received characters through a valid strobe with a byte.

After reset the block raises the select. It waits a settle period and sends the modem the command that puts it into text mode. It then waits again, drops the select and waits once more before it accepts verdicts. A verdict of 'P' or 'F' starts a transaction with this order:
- raise the select and let it settle;
- send the send-message command, which holds the recipient digits set by parameter;
- wait a settle period;
- send the verdict word, an end-of-message byte and a carriage return;
- wait, release the select and wait again.

Top module: `sms_alert_seq`

## Requirements
- R1: While reset is high, tx_valid and link_sel are low and busy is high. After reset the block sends the ten bytes `AT+CMGF=1` followed by 0x0D (carriage return), and only then is busy released.
- R2: A received 0x50 ('P') in idle starts a transaction whose message text is the four bytes `PASS`.
- R3: A received 0x46 ('F') in idle starts a transaction whose message text is the four bytes `FAIL`.
- R4: In idle, any received character other than 0x50 or 0x46 has no effect: no byte is transmitted, and link_sel and busy stay low.
- R5: Each transaction begins with `AT+CMGS=`, then 0x22 ('"'), then the NUM_LEN recipient digits in order, then 0x22, then 0x0D.
- R6: After the message text the block sends 0x1A (end of message) and then 0x0D.
- R7: Every byte is offered with link_sel high. link_sel is high for at least SETTLE_CYC cycles before the first byte of a transaction. It drops at least SETTLE_CYC cycles after the last accepted byte, and it is low in idle.
- R8: At least SETTLE_CYC cycles pass between the last accepted byte of the send command and the first offered byte of the message text.
- R9: busy is high in the cycle after a verdict is accepted and stays high until the transaction has ended. Characters received while busy, including during the start-up command, are dropped.
- R10: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value. A byte is consumed only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| tx_data | output | 8 | Byte offered to the UART transmitter |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| link_sel | output | 1 | Serial pair select: 1 = modem, 0 = host |
| busy | output | 1 | Start-up or message transaction in progress |

## Verification
The hardest case to reach is a verdict that arrives while a transaction is already running, and in particular while the transmitter is stalling a byte. That character must vanish without a trace. The stimulus injects a second verdict in the middle of a transaction while tx_ready follows an irregular pattern. It also injects one during the start-up command. The scoreboard then shows that no extra transaction appears. The settle windows are measured from the ports in the monitor, on both sides of the command-to-text gap.

// File: rtl/sms_alert_pkg.sv
package sms_alert_pkg;

  typedef enum logic [1:0] {
    SEG_SETUP = 2'd0,
    SEG_CMD   = 2'd1,
    SEG_BODY  = 2'd2
  } seg_e;

  typedef enum logic [2:0] {
    ST_BOOT = 3'd0,
    ST_PRE  = 3'd1,
    ST_SEND = 3'd2,
    ST_MID  = 3'd3,
    ST_POST = 3'd4,
    ST_REL  = 3'd5,
    ST_IDLE = 3'd6
  } state_e;

  localparam logic [7:0] ASC_CR    = 8'd13;
  localparam logic [7:0] ASC_SUB   = 8'd26;
  localparam logic [7:0] ASC_QUOTE = 8'h22;
  localparam logic [7:0] ASC_F     = 8'h46;
  localparam logic [7:0] ASC_P     = 8'h50;

endpackage

// File: rtl/sms_byte_rom.sv
module sms_byte_rom
  import sms_alert_pkg::*;
#(
  parameter int MAX_DIGITS = 16,
  parameter int NUM_LEN    = 10,
  parameter logic [8*MAX_DIGITS-1:0] RCPT = 128'("5550101234"),
  parameter int IW         = 5
) (
  input  seg_e          seg,
  input  logic [IW-1:0] idx,
  input  logic          fail,
  output logic [7:0]    byte_o,
  output logic [IW-1:0] len_o
);

  localparam logic [8*9-1:0] SETUP_S = "AT+CMGF=1";
  localparam logic [8*9-1:0] CMD_S   = {"AT+CMGS=", ASC_QUOTE};
  localparam logic [31:0]    PASS_S  = "PASS";
  localparam logic [31:0]    FAIL_S  = "FAIL";
  localparam int             CMD_LEN = NUM_LEN + 11;

  always_comb begin
    int i;
    i      = int'(idx);
    byte_o = ASC_CR;
    len_o  = '0;
    unique case (seg)
      SEG_SETUP: begin
        len_o = IW'(10);
        if (i < 9) byte_o = SETUP_S[8*(8-i) +: 8];
      end
      SEG_CMD: begin
        len_o = IW'(CMD_LEN);
        if (i < 9)                 byte_o = CMD_S[8*(8-i) +: 8];
        else if (i < 9 + NUM_LEN)  byte_o = RCPT[8*(NUM_LEN-1-(i-9)) +: 8];
        else if (i == 9 + NUM_LEN) byte_o = ASC_QUOTE;
      end
      SEG_BODY: begin
        len_o = IW'(6);
        if (i < 4)       byte_o = fail ? FAIL_S[8*(3-i) +: 8] : PASS_S[8*(3-i) +: 8];
        else if (i == 4) byte_o = ASC_SUB;
      end
      default: begin
        byte_o = ASC_CR;
        len_o  = '0;
      end
    endcase
  end

endmodule

// File: rtl/sms_settle_timer.sv
module sms_settle_timer #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= CW'(DLY);
    else if (!run || done)     cnt <= CW'(DLY);
    else                       cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);

  // R7 / R8: every wait window starts from a full count
  a_r7_full_window: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == CW'(DLY)));

endmodule

// File: rtl/sms_verdict_decode.sv
module sms_verdict_decode
  import sms_alert_pkg::*;
(
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       hit,
  output logic       fail
);

  assign fail = (rx_data == ASC_F);
  assign hit  = rx_valid && (fail || (rx_data == ASC_P));

endmodule

// File: rtl/sms_alert_seq.sv
module sms_alert_seq
  import sms_alert_pkg::*;
#(
  parameter int MAX_DIGITS = 16,
  parameter int NUM_LEN    = 10,
  parameter logic [8*MAX_DIGITS-1:0] RCPT = 128'("5550101234"),
  parameter int SETTLE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       link_sel,
  output logic       busy
);

  localparam int IW = $clog2(MAX_DIGITS + 12);

  state_e        state;
  seg_e          seg;
  logic [IW-1:0] idx;
  logic          fail_q;
  logic          tx_valid_q;
  logic [7:0]    tx_data_q;
  logic          sel_q;
  logic          busy_q;

  logic [7:0]    rom_byte;
  logic [IW-1:0] seg_len;
  logic          tmr_run, tmr_done;
  logic          v_hit, v_fail;

  sms_byte_rom #(
    .MAX_DIGITS(MAX_DIGITS), .NUM_LEN(NUM_LEN), .RCPT(RCPT), .IW(IW)
  ) u_rom (
    .seg(seg), .idx(idx), .fail(fail_q), .byte_o(rom_byte), .len_o(seg_len)
  );

  assign tmr_run = (state == ST_PRE) || (state == ST_MID) ||
                   (state == ST_POST) || (state == ST_REL);

  sms_settle_timer #(.DLY(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(tmr_run), .done(tmr_done)
  );

  sms_verdict_decode u_dec (
    .rx_valid(rx_valid), .rx_data(rx_data), .hit(v_hit), .fail(v_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_BOOT;
      seg        <= SEG_SETUP;
      idx        <= '0;
      fail_q     <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      sel_q      <= 1'b0;
      busy_q     <= 1'b1;
    end else begin
      unique case (state)
        ST_BOOT: begin
          sel_q <= 1'b1;
          seg   <= SEG_SETUP;
          state <= ST_PRE;
        end
        ST_PRE, ST_MID: begin
          if (tmr_done) begin
            idx   <= '0;
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (!tx_valid_q || tx_ready) begin
            if (idx < seg_len) begin
              tx_valid_q <= 1'b1;
              tx_data_q  <= rom_byte;
              idx        <= idx + 1'b1;
            end else begin
              tx_valid_q <= 1'b0;
              if (seg == SEG_CMD) begin
                seg   <= SEG_BODY;
                state <= ST_MID;
              end else begin
                state <= ST_POST;
              end
            end
          end
        end
        ST_POST: begin
          if (tmr_done) begin
            sel_q <= 1'b0;
            state <= ST_REL;
          end
        end
        ST_REL: begin
          if (tmr_done) begin
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (v_hit) begin
            fail_q <= v_fail;
            seg    <= SEG_CMD;
            sel_q  <= 1'b1;
            busy_q <= 1'b1;
            state  <= ST_PRE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_data  = tx_data_q;
  assign tx_valid = tx_valid_q;
  assign link_sel = sel_q;
  assign busy     = busy_q;

  // R10: a stalled byte is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7: bytes are only offered toward the modem, inside a busy window
  a_r7_sel_covers_tx: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (link_sel && busy));

  // R7: no byte right after the select is raised
  a_r7_settle_first: assert property (@(posedge clk) disable iff (rst)
    $rose(link_sel) |=> !tx_valid);

  // R4: a non-verdict character in idle leaves the block idle
  a_r4_ignore: assert property (@(posedge clk) disable iff (rst)
    (!busy && rx_valid && (rx_data != ASC_F) && (rx_data != ASC_P)) |=> !busy);

  // R9: an accepted verdict raises busy in the next cycle
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (!busy && rx_valid && ((rx_data == ASC_F) || (rx_data == ASC_P))) |=> busy);

  // R7 / R9: idle means link returned to host and nothing offered
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!link_sel && !tx_valid));

endmodule

// File: tb/tb_sms_alert_seq.sv
`timescale 1ns/1ps
module tb_sms_alert_seq;

  localparam int SETTLE  = 8;
  localparam int NUM_LEN = 10;
  localparam string NUM  = "5550101234";

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b1;
  logic       link_sel;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         mid_at = 0;

  always #2 clk = ~clk;

  sms_alert_seq #(.NUM_LEN(NUM_LEN), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .link_sel(link_sel), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic push_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) push(s[i], tag);
  endtask

  task automatic push_txn(input bit is_fail);
    mid_at = 11 + NUM_LEN;
    push_str("AT+CMGS=", "R5");
    push(8'h22, "R5");
    push_str(NUM, "R5");
    push(8'h22, "R5");
    push(8'd13, "R5");
    if (is_fail) push_str("FAIL", "R3");
    else         push_str("PASS", "R2");
    push(8'd26, "R6");
    push(8'd13, "R6");
  endtask

  task automatic pulse_rx(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check(1'b0, "R9 busy never released", 1, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // ready driver, changes just after the active edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
  end

  // monitor / scoreboard, samples at the falling edge
  logic       prev_sel = 1'b0, prev_valid = 1'b0, prev_ready = 1'b0;
  logic [7:0] prev_data = 8'h00;
  int rise_cyc = 0, last_hs = 0, hs_in_txn = 0;
  bit first_pend = 1'b0, gap_pend = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (link_sel && !prev_sel) begin
        rise_cyc = cyc; first_pend = 1'b1; hs_in_txn = 0;
      end
      if (tx_valid && !link_sel) check(1'b0, "R7 byte with select low", 0, 1);
      if (tx_valid && prev_valid && !prev_ready)
        check(tx_data == prev_data, "R10 stalled data changed", tx_data, prev_data);
      if (tx_valid && first_pend) begin
        check(cyc - rise_cyc >= SETTLE, "R7 select settle before first byte",
              cyc - rise_cyc, SETTLE);
        first_pend = 1'b0;
      end
      if (tx_valid && gap_pend) begin
        check(cyc - last_hs >= SETTLE, "R8 gap command to text", cyc - last_hs, SETTLE);
        gap_pend = 1'b0;
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R9 unexpected byte", tx_data, -1);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(tx_data == e, t, tx_data, e);
        end
        hs_in_txn++;
        last_hs = cyc + 1;
        if (hs_in_txn == mid_at) gap_pend = 1'b1;
      end
      if (!link_sel && prev_sel)
        check(cyc - last_hs >= SETTLE, "R7 settle before release", cyc - last_hs, SETTLE);
    end
    prev_sel = link_sel; prev_valid = tx_valid; prev_ready = tx_ready; prev_data = tx_data;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!tx_valid && !link_sel && busy, "R1 reset state",
          {tx_valid, link_sel, busy}, 3'b001);
    // start-up command
    mid_at = 0;
    push_str("AT+CMGF=1", "R1");
    push(8'd13, "R1");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    pulse_rx("P");                       // dropped: start-up in progress (R9)
    wait_idle();
    check(exp_q.size() == 0, "R1 setup bytes all sent", exp_q.size(), 0);
    repeat (30) @(negedge clk);
    check(!link_sel && !busy, "R9 start-up verdict dropped", {link_sel, busy}, 0);

    // ignored characters
    pulse_rx("X");
    pulse_rx("p");
    pulse_rx(8'h00);
    for (int k = 0; k < 3; k++) begin
      repeat (10) @(negedge clk);
      check(!busy && !link_sel && !tx_valid, "R4 other character ignored",
            {busy, link_sel, tx_valid}, 0);
    end

    // pass, transmitter always ready
    ready_mode = 0;
    push_txn(1'b0);
    pulse_rx("P");
    check(busy == 1'b1, "R9 busy after verdict", busy, 1);
    wait_idle();
    check(exp_q.size() == 0, "R2 pass transaction complete", exp_q.size(), 0);

    // fail, stalling transmitter, extra verdict mid-transaction
    ready_mode = 1;
    push_txn(1'b1);
    pulse_rx("F");
    check(busy == 1'b1, "R9 busy after verdict", busy, 1);
    repeat (25) @(negedge clk);
    pulse_rx("P");                       // dropped (R9)
    wait_idle();
    check(exp_q.size() == 0, "R3 fail transaction complete", exp_q.size(), 0);
    repeat (40) @(negedge clk);
    check(!busy && !link_sel, "R9 mid-transaction verdict dropped", {busy, link_sel}, 0);

    // back to back
    push_txn(1'b0);
    pulse_rx("P");
    wait_idle();
    ready_mode = 0;
    push_txn(1'b1);
    pulse_rx("F");
    wait_idle();
    check(exp_q.size() == 0, "R5 R6 back-to-back complete", exp_q.size(), 0);
    check(!link_sel, "R7 select low in idle", link_sel, 0);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule